// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block collects eight interrupt request lines, holds a pending bit for each rising request, and decides which of them may interrupt the processor. It keeps pending, mask and in-service state, and uses a fixed priority in which line 0 ranks highest. It raises `int_out` when a request may interrupt. When the processor acknowledges with a one-cycle `inta` pulse, the block returns an 8-bit vector. The upper five bits of the vector are a programmed base and the lower three bits are the winning line number.

Several copies can be joined into a two-level tree with up to 64 request lines. The `is_master` strap sets the role of a copy. A slave's `int_out` is wired to one request input of the master. On an acknowledge, the master looks at its cascade word, which is a bitmask of inputs that have slaves. For a slave input it puts the line number on the 3-bit cascade bus instead of returning a vector. Each slave compares the cascade bus with the identity held in the low three bits of its own cascade word, and only the slave that matches returns its vector. Software sets up the block through a small write port. Address 0 is the mode register: bit 0 is the standalone flag (reset value 1), bit 1 is automatic end-of-interrupt and bit 2 is special nesting. Address 1 holds the vector base in bits [7:3]. Address 2 is the cascade word. Address 3 is the mask, where a 1 blocks a line. A write of any data to address 4 is a non-specific end-of-interrupt.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, `int_out`, `cas_oe` and `data_oe` are low, the mask is clear, the standalone flag is 1, and nothing is pending or in service.
- R2: A request is captured on the rising edge of its input. With nothing in service and the line unmasked, `int_out` is high from the clock edge that captures it. A line held high after its acknowledge does not request again.
- R3: A masked line does not raise `int_out`, but its pending bit is kept. Clearing the mask bit raises `int_out` from the edge that writes the mask.
- R4: The vector is {base[7:3], line[2:0]}. When several lines are pending, the line with the lowest index wins.
- R5: When a non-slave acknowledge is serviced, the block clears the pending bit and sets the in-service bit. The vector is on the data bus with `data_oe` high for exactly one cycle, starting at the second clock edge after `inta` is sampled. `cas_oe` stays low.
- R6: A master in cascade mode that acknowledges a line whose cascade-word bit is set drives that line number on `cas_out` with `cas_oe` high for the one cycle after the first edge. It does not drive the data bus.
- R7: A slave takes an acknowledge only when `cas_in` equals bits [2:0] of its cascade word in the cycle after `inta`. It then returns its own vector in the following cycle. A slave whose identity does not match does not drive the data bus.
- R8: While a line is in service, requests on that line and on lower-priority lines do not raise `int_out`. Higher-priority requests do.
- R9: A non-specific end-of-interrupt clears only the highest-priority in-service bit.
- R10: With automatic end-of-interrupt set, an acknowledge leaves no in-service bit, so lower-priority lines are not blocked.
- R11: With special nesting set in a cascade master, a new request on a slave input that is already in service raises `int_out`. Without special nesting it does not.
- R12: A write to the cascade word is ignored while the standalone flag is 1.
- R13: `cas_oe` is asserted only by a master in cascade mode. A slave or a standalone block never asserts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | Role strap: 1 for master or standalone, 0 for slave |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| irq_in | input | 8 | Request lines, captured on rising edges |
| int_out | output | 1 | Interrupt request to the processor or master |
| inta | input | 1 | One-cycle acknowledge pulse |
| cas_in | input | 3 | Cascade bus as seen by a slave |
| cas_out | output | 3 | Cascade bus value driven by a master |
| cas_oe | output | 1 | Enable for `cas_out` |
| data_out | output | 8 | Vector |
| data_oe | output | 1 | Enable for `data_out` |

## Verification
Each result has a fixed latency. `int_out` is combinational from registered state, so it follows a captured request, a mask write or an end-of-interrupt in the cycle after the clock edge that performs it. A request on a slave reaches the master's `int_out` one edge later than it reaches the slave's. After an acknowledge, the cascade bus is valid in the cycle after the first edge and the vector in the cycle after the second edge, with the enables low again after the third. The bench drives inputs on falling edges and samples on the falling edge that follows each of those counted rising edges. A master and a slave are wired together so that routing, identity matching and nesting across the two levels are all exercised.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned NLINES = 8;
    localparam int unsigned LVL_W  = $clog2(NLINES);
    localparam int unsigned DATA_W = 8;
    localparam int unsigned BASE_W = DATA_W - LVL_W;
    localparam int unsigned ADDR_W = 3;

    typedef logic [NLINES-1:0] lvec_t;
    typedef logic [LVL_W-1:0]  lvl_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_MODE = 3'd0,
        REG_BASE = 3'd1,
        REG_CASC = 3'd2,
        REG_MASK = 3'd3,
        REG_EOI  = 3'd4
    } reg_sel_t;

    typedef struct packed {
        logic              single;
        logic              auto_eoi;
        logic              special_nest;
        logic [BASE_W-1:0] base;
        lvec_t             casc;
        lvec_t             mask;
    } cfg_t;

    typedef struct packed {
        logic valid;
        lvl_t lvl;
    } pick_t;

    // Lowest set index wins (index 0 is the highest priority).
    function automatic pick_t first_set(lvec_t v);
        pick_t p;
        p.valid = 1'b0;
        p.lvl   = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.valid = 1'b1;
                p.lvl   = lvl_t'(i);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg,
    output logic              eoi_cmd
);

    reg_sel_t sel;
    assign sel     = reg_sel_t'(addr);
    assign eoi_cmd = we && (sel == REG_EOI);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.single       <= 1'b1;
            cfg.auto_eoi     <= 1'b0;
            cfg.special_nest <= 1'b0;
            cfg.base         <= '0;
            cfg.casc         <= '0;
            cfg.mask         <= '0;
        end else if (we) begin
            case (sel)
                REG_MODE: begin
                    cfg.single       <= wdata[0];
                    cfg.auto_eoi     <= wdata[1];
                    cfg.special_nest <= wdata[2];
                end
                REG_BASE: cfg.base <= wdata[DATA_W-1:LVL_W];
                REG_CASC: if (!cfg.single) cfg.casc <= wdata;
                REG_MASK: cfg.mask <= wdata;
                default: ;
            endcase
        end
    end

    AST_CASC_GATED: assert property (@(posedge clk) disable iff (rst)
        (we && sel == REG_CASC && cfg.single) |=> $stable(cfg.casc))
        else $error("cascade word changed while standalone"); // R12

endmodule

// File: rtl/irqc_resolver.sv
module irqc_resolver
    import irqc_pkg::*;
(
    input  lvec_t irr,
    input  lvec_t isr,
    input  lvec_t mask,
    input  lvec_t casc,
    input  logic  sfnm_on,
    output pick_t best,
    output logic  int_req
);

    lvec_t elig;

    for (genvar g = 0; g < NLINES; g++) begin : g_lvl
        localparam lvec_t BELOW = lvec_t'((2 ** g) - 1);
        localparam lvec_t SELF  = lvec_t'(2 ** g);
        logic same_ok;
        assign same_ok = sfnm_on && casc[g];
        assign elig[g] = irr[g] && !mask[g] &&
                         ((isr & (same_ok ? BELOW : (BELOW | SELF))) == '0);
    end

    assign best    = first_set(elig);
    assign int_req = |elig;

endmodule

// File: rtl/irqc_core.sv
module irqc_core
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              is_master,
    input  cfg_t              cfg,
    input  logic              eoi_cmd,
    input  lvec_t             irq_in,
    input  logic              inta,
    input  lvl_t              cas_in,
    output logic              int_out,
    output lvl_t              cas_out,
    output logic              cas_oe,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);

    logic  slave_role, casc_master, sfnm_on;
    lvec_t irq_q, rise, irr, isr, irr_n, isr_n, take_hot;
    pick_t best, eoi_pick;
    logic  take, int_req, route_cas, inta_q, own_pend;
    lvl_t  take_lvl, own_lvl;

    assign slave_role  = !is_master && !cfg.single;
    assign casc_master = is_master && !cfg.single;
    assign sfnm_on     = casc_master && cfg.special_nest;
    assign rise        = irq_in & ~irq_q;

    irqc_resolver u_res (
        .irr     (irr),
        .isr     (isr),
        .mask    (cfg.mask),
        .casc    (cfg.casc),
        .sfnm_on (sfnm_on),
        .best    (best),
        .int_req (int_req)
    );

    assign int_out = int_req;

    always_comb begin
        take_lvl  = best.lvl;
        take_hot  = lvec_t'(1) << take_lvl;
        route_cas = casc_master && cfg.casc[take_lvl];
        if (slave_role)
            take = inta_q && (cas_in == cfg.casc[LVL_W-1:0]) && best.valid;
        else
            take = inta && best.valid;
        eoi_pick = first_set(isr);
        irr_n    = irr | rise;
        isr_n    = isr;
        if (eoi_cmd && eoi_pick.valid)
            isr_n[eoi_pick.lvl] = 1'b0;
        if (take) begin
            irr_n[take_lvl] = 1'b0;
            if (!cfg.auto_eoi)
                isr_n[take_lvl] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q    <= '0;
            irr      <= '0;
            isr      <= '0;
            inta_q   <= 1'b0;
            own_pend <= 1'b0;
            own_lvl  <= '0;
            cas_oe   <= 1'b0;
            cas_out  <= '0;
            data_oe  <= 1'b0;
            data_out <= '0;
        end else begin
            irq_q    <= irq_in;
            irr      <= irr_n;
            isr      <= isr_n;
            inta_q   <= inta;
            own_pend <= take && !slave_role && !route_cas;
            own_lvl  <= take_lvl;
            cas_oe   <= take && !slave_role && route_cas;
            cas_out  <= take_lvl;
            data_oe  <= own_pend || (take && slave_role);
            data_out <= {cfg.base, (slave_role ? take_lvl : own_lvl)};
        end
    end

    AST_INT_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((irr & ~cfg.mask) != '0))
        else $error("interrupt without unmasked request"); // R3

    AST_VEC_BASE: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> (data_out[DATA_W-1:LVL_W] == $past(cfg.base)))
        else $error("vector base mismatch"); // R4

    AST_ACK_CLEARS_REQ: assert property (@(posedge clk) disable iff (rst)
        take |=> ((irr & $past(take_hot)) == '0))
        else $error("pending bit kept after acknowledge"); // R5

    AST_EOI_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (eoi_cmd && isr != '0 && !take) |=> ($countones(isr) == $countones($past(isr)) - 1))
        else $error("end-of-interrupt cleared wrong count"); // R9

    AST_AEOI_NO_ISR: assert property (@(posedge clk) disable iff (rst)
        (take && cfg.auto_eoi && !eoi_cmd) |=> (isr == $past(isr)))
        else $error("auto end-of-interrupt left in-service bit"); // R10

    AST_CAS_ROLE: assert property (@(posedge clk) disable iff (rst)
        cas_oe |-> (is_master && !data_oe))
        else $error("cascade bus driven outside master role"); // R13

endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              is_master,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [NLINES-1:0] irq_in,
    output logic              int_out,
    input  logic              inta,
    input  logic [LVL_W-1:0]  cas_in,
    output logic [LVL_W-1:0]  cas_out,
    output logic              cas_oe,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);

    cfg_t cfg;
    logic eoi_cmd;

    irqc_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .cfg     (cfg),
        .eoi_cmd (eoi_cmd)
    );

    irqc_core u_core (
        .clk       (clk),
        .rst       (rst),
        .is_master (is_master),
        .cfg       (cfg),
        .eoi_cmd   (eoi_cmd),
        .irq_in    (irq_in),
        .inta      (inta),
        .cas_in    (cas_in),
        .int_out   (int_out),
        .cas_out   (cas_out),
        .cas_oe    (cas_oe),
        .data_out  (data_out),
        .data_oe   (data_oe)
    );

endmodule

// File: tb/cascade_irq_ctrl_tb.sv
module cascade_irq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       inta = 1'b0;
    logic [7:0] m_drv = '0, s_irq = '0;
    logic       m_we = 0, s_we = 0;
    logic [2:0] m_addr = '0, s_addr = '0;
    logic [7:0] m_wd = '0, s_wd = '0;

    logic       m_int, s_int, m_cas_oe, s_cas_oe, m_doe, s_doe;
    logic [2:0] m_cas, s_cas, s_cas_in;
    logic [7:0] m_dout, s_dout, m_irq, bus;

    int checks = 0, fails = 0, slv_cas_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign m_irq    = {m_drv[7:3], s_int, m_drv[1:0]};
    assign s_cas_in = m_cas_oe ? m_cas : 3'b111;
    assign bus      = m_doe ? m_dout : (s_doe ? s_dout : 8'hFF);

    cascade_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .is_master(1'b1),
        .cfg_we(m_we), .cfg_addr(m_addr), .cfg_wdata(m_wd),
        .irq_in(m_irq), .int_out(m_int), .inta(inta),
        .cas_in(3'b000), .cas_out(m_cas), .cas_oe(m_cas_oe),
        .data_out(m_dout), .data_oe(m_doe)
    );

    cascade_irq_ctrl u_slave (
        .clk(clk), .rst(rst), .is_master(1'b0),
        .cfg_we(s_we), .cfg_addr(s_addr), .cfg_wdata(s_wd),
        .irq_in(s_irq), .int_out(s_int), .inta(inta),
        .cas_in(s_cas_in), .cas_out(s_cas), .cas_oe(s_cas_oe),
        .data_out(s_dout), .data_oe(s_doe)
    );

    always @(negedge clk) if (!rst && s_cas_oe) slv_cas_cnt++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit to_slave, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        if (to_slave) begin s_we = 1; s_addr = a; s_wd = d; end
        else begin m_we = 1; m_addr = a; m_wd = d; end
        @(negedge clk);
        s_we = 0; m_we = 0;
    endtask

    // Acknowledge; samples cascade phase, vector phase and release phase.
    task automatic ack(output logic [7:0] vec, output bit mc, output logic [2:0] cv,
                       output bit md, output bit sd, output bit early, output bit late);
        @(negedge clk); inta = 1;
        @(negedge clk); inta = 0;
        mc = m_cas_oe; cv = m_cas; early = m_doe | s_doe;
        @(negedge clk);
        md = m_doe; sd = s_doe; vec = bus;
        @(negedge clk);
        late = m_doe | s_doe | m_cas_oe;
    endtask

    logic [7:0] v; logic [2:0] cv; bit mc, md, sd, e, l;

    task automatic t_reset();
        chk("R1 master int", m_int, 0);
        chk("R1 slave int", s_int, 0);
        chk("R1 enables", {m_cas_oe, m_doe, s_doe}, 0);
    endtask

    task automatic t_standalone();
        wr(0, 3'd2, 8'h08);            // ignored: standalone flag still 1
        wr(0, 3'd0, 8'h00);
        wr(0, 3'd1, 8'h40);
        wr(1, 3'd0, 8'h00);
        wr(1, 3'd1, 8'h80);
        wr(1, 3'd2, 8'h02);
        @(negedge clk); m_drv[3] = 1;
        @(negedge clk); chk("R2 int after capture", m_int, 1);
        ack(v, mc, cv, md, sd, e, l);
        chk("R12 ignored cascade word, no cas", mc, 0);
        chk("R5 no data in first cycle", e, 0);
        chk("R5 own vector driven", md, 1);
        chk("R5 vector value", v, 8'h43);
        chk("R5 data released", l, 0);
        chk("R5 in service blocks", m_int, 0);
        wr(0, 3'd4, 8'h00);
        chk("R2 held line no re-request", m_int, 0);
        m_drv[3] = 0;
        wr(0, 3'd2, 8'h04);
    endtask

    task automatic t_priority();
        @(negedge clk); m_drv[5] = 1; m_drv[1] = 1;
        @(negedge clk); chk("R2 int", m_int, 1);
        ack(v, mc, cv, md, sd, e, l);
        chk("R4 lowest index wins", v, 8'h41);
        chk("R8 lower blocked", m_int, 0);
        wr(0, 3'd4, 8'h00);
        chk("R9 eoi re-enables", m_int, 1);
        ack(v, mc, cv, md, sd, e, l);
        chk("R4 next vector", v, 8'h45);
        @(negedge clk); m_drv[6] = 1;
        @(negedge clk); chk("R8 lower under service", m_int, 0);
        m_drv[0] = 1;
        @(negedge clk); chk("R8 higher passes", m_int, 1);
        ack(v, mc, cv, md, sd, e, l);
        chk("R4 vector 0", v, 8'h40);
        wr(0, 3'd4, 8'h00);
        chk("R9 only top cleared", m_int, 0);
        wr(0, 3'd4, 8'h00);
        chk("R9 second eoi", m_int, 1);
        ack(v, mc, cv, md, sd, e, l);
        chk("R4 vector 6", v, 8'h46);
        wr(0, 3'd4, 8'h00);
        m_drv = '0;
    endtask

    task automatic t_mask();
        wr(0, 3'd3, 8'h10);
        @(negedge clk); m_drv[4] = 1;
        repeat (2) @(negedge clk);
        chk("R3 masked", m_int, 0);
        wr(0, 3'd3, 8'h00);
        chk("R3 unmask raises", m_int, 1);
        ack(v, mc, cv, md, sd, e, l);
        chk("R3 kept request vector", v, 8'h44);
        wr(0, 3'd4, 8'h00);
        m_drv[4] = 0;
    endtask

    task automatic t_cascade();
        @(negedge clk); s_irq[5] = 1; m_drv[0] = 1;
        repeat (3) @(negedge clk);
        chk("R2 master int", m_int, 1);
        ack(v, mc, cv, md, sd, e, l);
        chk("R7 no slave on mismatch", sd, 0);
        chk("R5 master own vector", v, 8'h40);
        chk("R6 no cas for own line", mc, 0);
        chk("R8 slave line blocked", m_int, 0);
        wr(0, 3'd4, 8'h00);
        chk("R9 slave line passes", m_int, 1);
        ack(v, mc, cv, md, sd, e, l);
        chk("R6 cas enabled", mc, 1);
        chk("R6 cas value", cv, 2);
        chk("R6 no data first cycle", e, 0);
        chk("R6 master data off", md, 0);
        chk("R7 slave drives", sd, 1);
        chk("R7 slave vector", v, 8'h85);
        m_drv[0] = 0;
        chk("R8 slave int low", s_int, 0);
        @(negedge clk); s_irq[1] = 1;
        repeat (3) @(negedge clk);
        chk("R8 slave higher passes", s_int, 1);
        chk("R11 blocked without special nesting", m_int, 0);
        wr(0, 3'd0, 8'h04);
        chk("R11 special nesting passes", m_int, 1);
        ack(v, mc, cv, md, sd, e, l);
        chk("R11 cas value", cv, 2);
        chk("R11 nested slave vector", v, 8'h81);
        wr(1, 3'd4, 8'h00);
        wr(1, 3'd4, 8'h00);
        wr(0, 3'd4, 8'h00);
        chk("R9 master idle", m_int, 0);
        chk("R9 slave idle", s_int, 0);
        s_irq = '0;
        wr(0, 3'd0, 8'h00);
    endtask

    task automatic t_aeoi();
        wr(0, 3'd0, 8'h02);
        @(negedge clk); m_drv[4] = 1;
        @(negedge clk);
        ack(v, mc, cv, md, sd, e, l);
        chk("R10 vector", v, 8'h44);
        m_drv[6] = 1;
        @(negedge clk); chk("R10 lower not blocked", m_int, 1);
        ack(v, mc, cv, md, sd, e, l);
        chk("R10 lower vector", v, 8'h46);
        chk("R10 idle", m_int, 0);
        m_drv = '0;
        wr(0, 3'd0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_standalone();
        t_priority();
        t_mask();
        t_cascade();
        t_aeoi();
        chk("R13 slave never drives cas", slv_cas_cnt, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule